// File: doc/BRIEF.md
# Selectable Digital Phase Detector

This block compares a reference square wave with the feedback square wave of a digital loop. It produces a single error bit, and that bit is meant to drive the up/down control of a downstream loop counter. The error bit is a duty-cycle signal: the fraction of time it spends high, minus the fraction of time it spends low, moves linearly with the phase error between the two inputs. At zero phase error the error bit is a 50% square wave. At either end of the linear range it stays high all the time or low all the time.

One select input picks the detector type:

- **XOR type.** The two inputs are combined with an exclusive-OR. Zero error is reached when the inputs are a quarter cycle apart. The gain is 4 per cycle of error.
- **Edge-driven type.** This is a set/clear flip-flop. A rising edge on the reference sets it and a rising edge on the feedback clears it. Zero error is reached when the inputs are half a cycle apart. The gain is 2 per cycle of error.

Both inputs are first resynchronised to the system clock. All decisions are made on the synchronised copies. The output is registered.

Top module: `phase_det_sel`

## Requirements
- R1: While `rst` is high at a clock edge, `err_out` is 0 after that edge. Synchronizer and detector state are cleared as well, so no stale edge appears after release.
- R2: With `mode_sel`=0 (XOR type), `err_out` equals `ref_in` XOR `fb_in` as they were 3 clock edges earlier (2 synchronizer stages plus 1 output register).
- R3: In XOR type, square inputs of period P offset by P/4 give an `err_out` that is high for exactly P/2 clocks per period.
- R4: With `mode_sel`=1 (edge-driven type), a rising edge on `ref_in` alone sets `err_out` to 1 on the 3rd clock edge after the input change.
- R5: In edge-driven type, a rising edge on `fb_in` alone clears `err_out` to 0 with the same 3-edge latency.
- R6: In edge-driven type, when both synchronised inputs rise in the same cycle, the detector state is unchanged.
- R7: In edge-driven type, input levels and falling edges have no effect. A held-high reference does not set the output again after a feedback clear.
- R8: In edge-driven type, square inputs of period P offset by P/2 give an `err_out` that is high for exactly P/2 clocks per period.
- R9: In XOR type, in-phase inputs give a constantly low output and antiphase inputs give a constantly high output.
- R10: A change of `mode_sel` shows on `err_out` after one clock edge, and the output then reflects the newly selected type. The edge-driven state keeps tracking while XOR type is selected.
- R11: The high time per period is linear in the offset D (clocks, 0 ≤ D < P). It is 2·min(D, P−D) in XOR type and D in edge-driven type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference square wave (asynchronous) |
| fb_in | input | 1 | Loop feedback square wave (asynchronous) |
| mode_sel | input | 1 | Detector type: 0 = XOR, 1 = edge-driven |
| err_out | output | 1 | Registered phase error bit |

## Verification
The bench sweeps the phase offset for both detector types and counts the high clocks per period. A wrong gain or a wrong zero-error point then shows up as a miscounted duty cycle, and a flipped polarity shows up as a mirrored one.

Directed cases cover the following:
- Simultaneous rising edges. A design that lets one edge win here would drift high or low at zero offset.
- Level sensitivity. A detector that sets on the reference level rather than its edge would re-raise the output right after a feedback clear.
- Mode switching while the edge state sits opposite the XOR value. This exposes a wrong select polarity or a stalled edge state.
- Reset in the middle of activity. A design that does not clear the synchronizers would emit a phantom edge after reset is released.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic {
    PD_XOR  = 1'b0,
    PD_EDGE = 1'b1
  } pd_mode_e;

  localparam int unsigned PD_SYNC_MIN = 2;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  // R1: chain is empty one edge after reset
  p_sync_clear_r1: assert property (@(posedge clk) rst |=> (chain_q == '0));
endmodule

// File: rtl/pd_rise.sv
module pd_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/pd_ec_core.sv
module pd_ec_core (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_ev,
  output logic state_nx
);
  logic state_q;

  always_comb begin
    state_nx = state_q;
    if (set_ev && !clr_ev)      state_nx = 1'b1;
    else if (clr_ev && !set_ev) state_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= 1'b0;
    else     state_q <= state_nx;
  end

  p_set_on_ref_r4: assert property (@(posedge clk) disable iff (rst)
    (set_ev && !clr_ev) |=> state_q);
  p_clr_on_fb_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_ev && !set_ev) |=> !state_q);
  p_hold_tie_r6: assert property (@(posedge clk) disable iff (rst)
    (set_ev == clr_ev) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/phase_det_sel.sv
module phase_det_sel
  import pd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  input  logic mode_sel,
  output logic err_out
);
  localparam int unsigned STG = (SYNC_STAGES < PD_SYNC_MIN) ? PD_SYNC_MIN : SYNC_STAGES;

  logic ref_s, fb_s;
  logic ref_rise, fb_rise;
  logic ec_nx;
  logic xor_val;
  logic err_q;
  pd_mode_e mode;

  pd_sync #(.STAGES(STG)) u_sync_ref (.clk(clk), .rst(rst), .d(ref_in), .q(ref_s));
  pd_sync #(.STAGES(STG)) u_sync_fb  (.clk(clk), .rst(rst), .d(fb_in),  .q(fb_s));

  pd_rise u_rise_ref (.clk(clk), .rst(rst), .lvl(ref_s), .rise(ref_rise));
  pd_rise u_rise_fb  (.clk(clk), .rst(rst), .lvl(fb_s),  .rise(fb_rise));

  pd_ec_core u_ec (
    .clk     (clk),
    .rst     (rst),
    .set_ev  (ref_rise),
    .clr_ev  (fb_rise),
    .state_nx(ec_nx)
  );

  assign xor_val = ref_s ^ fb_s;
  assign mode    = pd_mode_e'(mode_sel);

  always_ff @(posedge clk) begin
    if (rst)                  err_q <= 1'b0;
    else if (mode == PD_EDGE) err_q <= ec_nx;
    else                      err_q <= xor_val;
  end

  assign err_out = err_q;

  p_rst_low_r1: assert property (@(posedge clk) rst |=> !err_out);
  p_xor_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 1'b0) |=> (err_out == ($past(ref_s) ^ $past(fb_s))));
  p_edge_set_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_sel && ref_rise && !fb_rise) |=> err_out);
  p_edge_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_sel && fb_rise && !ref_rise) |=> !err_out);
endmodule

// File: tb/phase_det_sel_tb_top.sv
module phase_det_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {mode, period, offset, expected high clocks per period}
  localparam int VEC [NVEC][4] = '{
    '{0, 16, 0, 0},  '{0, 16, 2, 4},  '{0, 16, 4, 8},  '{0, 16, 8, 16},
    '{0, 16, 12, 8}, '{0, 20, 5, 10}, '{1, 16, 4, 4},  '{1, 16, 8, 8},
    '{1, 16, 12, 12}, '{1, 16, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic mode_sel = 1'b0;
  logic err_out;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_det_sel dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .mode_sel(mode_sel), .err_out(err_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
    tick(3);
    rst = 1'b0;
  endtask

  function automatic string vec_tag(input int m, input int p, input int d);
    if (m == 0 && (d == 0 || d == p/2)) return "R9";
    if (m == 0 && d == p/4)             return "R3";
    if (m == 1 && d == p/2)             return "R8";
    if (m == 1 && d == 0)               return "R6";
    return "R11";
  endfunction

  initial begin
    // R1 reset state
    tick(2);
    check("R1", int'(err_out), 0);

    // duty-cycle sweep
    for (int v = 0; v < NVEC; v++) begin
      int p, d, hi;
      p = VEC[v][1];
      d = VEC[v][2];
      hi = 0;
      do_reset();
      mode_sel = VEC[v][0][0];
      for (int t = 0; t < 14*p; t++) begin
        if (t >= 8*p && t < 12*p && err_out) hi++;
        ref_in = ((t % p) < p/2);
        fb_in  = (((t - d + 100*p) % p) < p/2);
        tick(1);
      end
      check(vec_tag(VEC[v][0], p, d), hi, 4*VEC[v][2+1]);
    end

    // R2: XOR latency of 3 edges
    do_reset();
    mode_sel = 1'b0;
    ref_in = 1'b1;
    tick(2);
    check("R2", int'(err_out), 0);
    tick(1);
    check("R2", int'(err_out), 1);

    // R4 / R5 edge-driven set and clear latency
    do_reset();
    mode_sel = 1'b1;
    ref_in = 1'b1;
    tick(2);
    check("R4", int'(err_out), 0);
    tick(1);
    check("R4", int'(err_out), 1);
    fb_in = 1'b1;
    tick(3);
    check("R5", int'(err_out), 0);

    // R7 levels and falling edges ignored (ref still high)
    tick(5);
    check("R7", int'(err_out), 0);
    fb_in = 1'b0;
    tick(5);
    check("R7", int'(err_out), 0);

    // R10 mode switch: xor value is 1, edge state is 0
    mode_sel = 1'b0;
    tick(1);
    check("R10", int'(err_out), 1);
    mode_sel = 1'b1;
    tick(1);
    check("R10", int'(err_out), 0);
    // edge state tracks while XOR is selected
    mode_sel = 1'b0;
    ref_in = 1'b0;
    tick(3);
    ref_in = 1'b1;
    tick(4);
    mode_sel = 1'b1;
    tick(1);
    check("R10", int'(err_out), 1);

    // R6 simultaneous rises hold state (state currently 1)
    ref_in = 1'b0; fb_in = 1'b0;
    tick(4);
    ref_in = 1'b1; fb_in = 1'b1;
    tick(5);
    check("R6", int'(err_out), 1);

    // R1 reset mid-activity, no phantom edge after release
    rst = 1'b1;
    tick(1);
    check("R1", int'(err_out), 0);
    rst = 1'b0;
    tick(5);
    check("R1", int'(err_out), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule